// File: doc/BRIEF.md
# Resumable NMI trap controller

This block is the machine-mode trap-control slice of a hart that supports non-maskable interrupts which can be resumed. It owns four NMI control registers (scratch, saved PC, cause, saved status) and a hidden enable flag. Each cycle it looks at the NMI request, the exception request, the current PC and privilege, and the NMI-return strobe. It then decides whether the hart must be redirected, and where. A CSR read/write port gives software access to the four registers.

When an NMI is accepted, the interrupted context is saved and the hart is sent to the NMI interrupt vector in machine mode. The hidden flag is also cleared. While the flag is clear, further NMIs are held off and every other interrupt is disabled. An exception taken while the flag is clear goes to a separate NMI exception vector. Its state is handed out for the ordinary machine trap registers to store. The NMI-return strobe sets the flag again and resumes the saved context. The pipeline around this block supplies the strobes and consumes the redirect.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: After reset the hidden enable flag is set, so `irq_disable_o` is 0. All four NMI registers read as zero, and any address outside 0x350..0x353 reads as zero.
- R2: An NMI request accepted while the flag is set produces `redirect_o`=1 to `NMI_VEC` with `priv_o`=3 (machine). From the next cycle, address 0x351 holds the PC with bit 0 cleared, bits [12:11] of address 0x353 hold the interrupted privilege, and `irq_disable_o` is 1.
- R3: On NMI entry the cause register at 0x352 becomes bit XLEN-1 set, the low CODE_W bits equal to the NMI code, and zeros in between.
- R4: The registers at 0x350 (scratch), 0x351 (saved PC), 0x352 (cause) and 0x353 (status) are read/write. Bit 0 of 0x351 always reads 0. Only bits [12:11] of 0x353 are stored; its other bits read 0.
- R5: While the flag is clear, an NMI request causes no redirect and leaves `irq_disable_o` at 1.
- R6: An NMI request with the flag set wins over an exception or NMI return in the same cycle, and the saved PC is that cycle's PC.
- R7: An NMI return in machine mode with no exception redirects to the saved PC with `priv_o` equal to the saved status bits [12:11], and clears `irq_disable_o` from the next cycle.
- R8: An NMI return outside machine mode raises `illegal_o` (cause code 2). It does not redirect to the saved PC and leaves the flag and NMI registers unchanged. If the flag is clear, it is handled as in R9 with cause 2.
- R9: An exception while the flag is clear asserts `mtrap_we_o`, with `mepc_o` = PC, `mcause_o` = exception cause and `mpp_o` = 3. It redirects to `NMI_EXC_VEC` in machine mode, and the NMI registers stay unchanged.
- R10: An exception while the flag is set, with no NMI request, produces no redirect and no `mtrap_we_o`.
- R11: A CSR write to 0x351, 0x352 or 0x353 in the cycle of an NMI entry is overridden by the entry's hardware update.
- R12: No CSR write changes the hidden flag; it falls only on NMI entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_req_i | input | 1 | NMI request level |
| nmi_code_i | input | CODE_W | NMI cause code |
| exc_req_i | input | 1 | Exception raised by the current instruction |
| exc_cause_i | input | XLEN | Exception cause value |
| pc_i | input | XLEN | PC of the current instruction |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mnret_i | input | 1 | NMI-return instruction strobe |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| redirect_o | output | 1 | Fetch must be redirected this cycle |
| redirect_pc_o | output | XLEN | Redirect target, zero when no redirect |
| priv_o | output | 2 | Privilege after this cycle |
| irq_disable_o | output | 1 | All ordinary interrupts disabled (flag clear) |
| illegal_o | output | 1 | NMI return attempted outside machine mode |
| mtrap_we_o | output | 1 | Write ordinary machine trap registers |
| mepc_o | output | XLEN | Value for the ordinary exception PC |
| mcause_o | output | XLEN | Value for the ordinary cause |
| mpp_o | output | 2 | Value for the ordinary previous-privilege field |

## Verification
The assertions assume that the pipeline holds the privilege input at one of the three legal encodings. They also assume that NMI-return and exception strobes reflect a single retiring instruction per cycle, and that CSR writes reaching the block are already privilege-checked. The stimulus drives only priv values 0, 1 and 3. It changes inputs once per cycle, away from the clock edge, and builds each corner case (simultaneous NMI, exception and return; a write colliding with an entry; returns from lower modes) from those legal combinations.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [11:0] ADDR_SCRATCH = 12'h350;
  localparam logic [11:0] ADDR_EPC     = 12'h351;
  localparam logic [11:0] ADDR_CAUSE   = 12'h352;
  localparam logic [11:0] ADDR_STATUS  = 12'h353;

  localparam int PP_LO     = 11;
  localparam int ILL_CAUSE = 2;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_NMI,
    ACT_NEXC,
    ACT_RET
  } act_e;
endpackage

// File: rtl/rnmi_arbiter.sv
module rnmi_arbiter
  import rnmi_pkg::*;
(
  input  logic       en_i,
  input  logic       nmi_req_i,
  input  logic       exc_req_i,
  input  logic       mnret_i,
  input  logic [1:0] priv_i,
  output act_e       act_o,
  output logic       ill_o,
  output logic       exc_any_o
);
  always_comb begin
    ill_o     = mnret_i && (priv_i != PRIV_M);
    exc_any_o = exc_req_i || ill_o;
    if (nmi_req_i && en_i)
      act_o = ACT_NMI;
    else if (exc_any_o && !en_i)
      act_o = ACT_NEXC;
    else if (mnret_i && !ill_o && !exc_req_i)
      act_o = ACT_RET;
    else
      act_o = ACT_NONE;
  end
endmodule

// File: rtl/rnmi_enable.sv
module rnmi_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic ret_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b1;
    else if (take_i) en_q <= 1'b0;
    else if (ret_i)  en_q <= 1'b1;
  end

  assign en_o = en_q;
endmodule

// File: rtl/rnmi_csr_file.sv
module rnmi_csr_file
  import rnmi_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 4,
  parameter bit HAS_CODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic              take_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [1:0]        pp_o
);
  localparam int PAD_W  = XLEN - 1 - CODE_W;
  localparam int HI_W   = XLEN - PP_LO - 2;

  logic [XLEN-1:0] scratch_q, epc_q, cause_q;
  logic [1:0]      pp_q;
  logic [XLEN-1:0] cause_entry;
  logic            wr_scratch, wr_epc, wr_cause, wr_status;

  generate
    if (HAS_CODE) begin : g_code
      assign cause_entry = {1'b1, {PAD_W{1'b0}}, code_i};
    end else begin : g_nocode
      assign cause_entry = {1'b1, {(XLEN-1){1'b0}}};
    end
  endgenerate

  assign wr_scratch = we_i && (addr_i == ADDR_SCRATCH);
  assign wr_epc     = we_i && (addr_i == ADDR_EPC);
  assign wr_cause   = we_i && (addr_i == ADDR_CAUSE);
  assign wr_status  = we_i && (addr_i == ADDR_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scratch_q <= '0;
    else if (wr_scratch) scratch_q <= wdata_i;
  end

  // entry update takes precedence over a colliding software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= '0;
      pp_q    <= PRIV_U;
    end else if (take_i) begin
      epc_q   <= {pc_i[XLEN-1:1], 1'b0};
      cause_q <= cause_entry;
      pp_q    <= priv_i;
    end else begin
      if (wr_epc)    epc_q   <= {wdata_i[XLEN-1:1], 1'b0};
      if (wr_cause)  cause_q <= wdata_i;
      if (wr_status) pp_q    <= wdata_i[PP_LO+1:PP_LO];
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_SCRATCH: rdata_o = scratch_q;
      ADDR_EPC:     rdata_o = epc_q;
      ADDR_CAUSE:   rdata_o = cause_q;
      ADDR_STATUS:  rdata_o = {{HI_W{1'b0}}, pp_q, {PP_LO{1'b0}}};
      default:      rdata_o = '0;
    endcase
  end

  assign epc_o = epc_q;
  assign pp_o  = pp_q;
endmodule

// File: rtl/rnmi_trap_ctrl.sv
module rnmi_trap_ctrl
  import rnmi_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              CODE_W      = 4,
  parameter bit              HAS_CODE    = 1'b1,
  parameter logic [XLEN-1:0] NMI_VEC     = 32'h0000_1000,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 32'h0000_1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_req_i,
  input  logic [CODE_W-1:0] nmi_code_i,
  input  logic              exc_req_i,
  input  logic [XLEN-1:0]   exc_cause_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [1:0]        priv_i,
  input  logic              mnret_i,
  input  logic              csr_we_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic [1:0]        priv_o,
  output logic              irq_disable_o,
  output logic              illegal_o,
  output logic              mtrap_we_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [1:0]        mpp_o
);
  act_e            act;
  logic            en, ill, exc_any;
  logic [XLEN-1:0] saved_epc;
  logic [1:0]      saved_pp;

  rnmi_arbiter u_arb (
    .en_i      (en),
    .nmi_req_i (nmi_req_i),
    .exc_req_i (exc_req_i),
    .mnret_i   (mnret_i),
    .priv_i    (priv_i),
    .act_o     (act),
    .ill_o     (ill),
    .exc_any_o (exc_any)
  );

  rnmi_enable u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (act == ACT_NMI),
    .ret_i  (act == ACT_RET),
    .en_o   (en)
  );

  rnmi_csr_file #(
    .XLEN     (XLEN),
    .CODE_W   (CODE_W),
    .HAS_CODE (HAS_CODE)
  ) u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .take_i  (act == ACT_NMI),
    .pc_i    (pc_i),
    .code_i  (nmi_code_i),
    .priv_i  (priv_i),
    .rdata_o (csr_rdata_o),
    .epc_o   (saved_epc),
    .pp_o    (saved_pp)
  );

  always_comb begin
    redirect_o    = 1'b0;
    redirect_pc_o = '0;
    priv_o        = priv_i;
    unique case (act)
      ACT_NMI: begin
        redirect_o    = 1'b1;
        redirect_pc_o = NMI_VEC;
        priv_o        = PRIV_M;
      end
      ACT_NEXC: begin
        redirect_o    = 1'b1;
        redirect_pc_o = NMI_EXC_VEC;
        priv_o        = PRIV_M;
      end
      ACT_RET: begin
        redirect_o    = 1'b1;
        redirect_pc_o = saved_epc;
        priv_o        = saved_pp;
      end
      default: ;
    endcase
  end

  assign irq_disable_o = !en;
  assign illegal_o     = ill;
  assign mtrap_we_o    = (act == ACT_NEXC) && exc_any;
  assign mepc_o        = pc_i;
  assign mcause_o      = exc_req_i ? exc_cause_i : XLEN'(ILL_CAUSE);
  assign mpp_o         = PRIV_M;
endmodule

// File: rtl/rnmi_trap_ctrl_chk.sv
module rnmi_trap_ctrl_chk #(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] NMI_VEC     = 32'h0000_1000,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 32'h0000_1100
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            nmi_req_i,
  input logic            exc_req_i,
  input logic [1:0]      priv_i,
  input logic            mnret_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            irq_disable_o,
  input logic            illegal_o,
  input logic            mtrap_we_o,
  input logic [1:0]      mpp_o
);
  // R2
  nmi_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_i && !irq_disable_o) |-> (redirect_o && redirect_pc_o == NMI_VEC) ##1 irq_disable_o);

  // R5
  nmi_nested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_disable_o && nmi_req_i) |-> !(redirect_o && redirect_pc_o == NMI_VEC));

  // R7
  ret_reenable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_disable_o && mnret_i && priv_i == 2'd3 && !exc_req_i) |=> !irq_disable_o);

  // R8
  ret_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnret_i && priv_i != 2'd3) |-> illegal_o);

  // R8
  ret_illegal_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnret_i && priv_i != 2'd3 && !nmi_req_i) |=> $stable(irq_disable_o));

  // R9
  exc_nested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_disable_o && exc_req_i) |-> (mtrap_we_o && mpp_o == 2'd3 && redirect_pc_o == NMI_EXC_VEC));

  // R10
  exc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_disable_o && !nmi_req_i && !mnret_i) |-> (!redirect_o && !mtrap_we_o));

  // R12
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_disable_o) |-> $past(nmi_req_i));
endmodule

bind rnmi_trap_ctrl rnmi_trap_ctrl_chk #(
  .XLEN        (XLEN),
  .NMI_VEC     (NMI_VEC),
  .NMI_EXC_VEC (NMI_EXC_VEC)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .nmi_req_i     (nmi_req_i),
  .exc_req_i     (exc_req_i),
  .priv_i        (priv_i),
  .mnret_i       (mnret_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .irq_disable_o (irq_disable_o),
  .illegal_o     (illegal_o),
  .mtrap_we_o    (mtrap_we_o),
  .mpp_o         (mpp_o)
);

// File: tb/rnmi_trap_ctrl_tb_top.sv
module rnmi_trap_ctrl_tb_top;
  localparam logic [31:0] VEC_I = 32'h0000_1000;
  localparam logic [31:0] VEC_E = 32'h0000_1100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nmi_req_i = 1'b0;
  logic [3:0]  nmi_code_i = '0;
  logic        exc_req_i = 1'b0;
  logic [31:0] exc_cause_i = '0;
  logic [31:0] pc_i = '0;
  logic [1:0]  priv_i = 2'd3;
  logic        mnret_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o, redirect_pc_o, mepc_o, mcause_o;
  logic        redirect_o, irq_disable_o, illegal_o, mtrap_we_o;
  logic [1:0]  priv_o, mpp_o;

  always #4 clk_i = ~clk_i;

  rnmi_trap_ctrl #(
    .XLEN(32), .CODE_W(4), .HAS_CODE(1'b1), .NMI_VEC(VEC_I), .NMI_EXC_VEC(VEC_E)
  ) dut_i (.*);

  typedef struct {
    string       req;
    logic        redir;
    logic [31:0] rpc;
    logic [1:0]  priv;
    logic        dis;
    logic        ill;
    logic        mwe;
    logic [31:0] mepc;
    logic [31:0] mcause;
    logic [31:0] rdata;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // reference state, from the requirements
  logic        m_en = 1'b1;
  logic [31:0] m_scr = '0, m_epc = '0, m_cause = '0;
  logic [1:0]  m_pp = 2'd0;

  function automatic logic [31:0] rd(input logic [11:0] a);
    case (a)
      12'h350: return m_scr;
      12'h351: return m_epc;
      12'h352: return m_cause;
      12'h353: return {19'd0, m_pp, 11'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic nmi, input logic [3:0] code,
                      input logic exc, input logic [31:0] cause, input logic [31:0] pc,
                      input logic [1:0] priv, input logic ret, input logic we,
                      input logic [11:0] addr, input logic [31:0] wd);
    exp_t e;
    logic ill, take, nexc, rett;
    @(negedge clk_i);
    nmi_req_i = nmi; nmi_code_i = code; exc_req_i = exc; exc_cause_i = cause;
    pc_i = pc; priv_i = priv; mnret_i = ret; csr_we_i = we; csr_addr_i = addr; csr_wdata_i = wd;
    ill  = ret && priv != 2'd3;
    take = nmi && m_en;
    nexc = !take && (exc || ill) && !m_en;
    rett = !take && !nexc && ret && !ill && !exc;
    e.req    = req;
    e.redir  = take || nexc || rett;
    e.rpc    = take ? VEC_I : nexc ? VEC_E : rett ? m_epc : 32'd0;
    e.priv   = (take || nexc) ? 2'd3 : rett ? m_pp : priv;
    e.dis    = !m_en;
    e.ill    = ill;
    e.mwe    = nexc;
    e.mepc   = pc;
    e.mcause = exc ? cause : 32'd2;
    e.rdata  = rd(addr);
    q.push_back(e);
    if (we) begin
      if (addr == 12'h350) m_scr = wd;
      if (!take) begin
        if (addr == 12'h351) m_epc = {wd[31:1], 1'b0};
        if (addr == 12'h352) m_cause = wd;
        if (addr == 12'h353) m_pp = wd[12:11];
      end
    end
    if (take) begin
      m_epc = {pc[31:1], 1'b0};
      m_cause = {1'b1, 27'd0, code};
      m_pp = priv;
      m_en = 1'b0;
    end else if (rett) m_en = 1'b1;
  endtask

  task automatic idle_rd(input string req, input logic [11:0] a);
    step(req, 0, 0, 0, 0, 32'h100, 2'd3, 0, 0, a, 0);
  endtask

  // monitor: sample mid low phase, compare against the oldest expectation
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "redirect", {31'd0, redirect_o}, {31'd0, e.redir});
        chk(e.req, "redirect_pc", redirect_pc_o, e.rpc);
        chk(e.req, "priv", {30'd0, priv_o}, {30'd0, e.priv});
        chk(e.req, "irq_disable", {31'd0, irq_disable_o}, {31'd0, e.dis});
        chk(e.req, "illegal", {31'd0, illegal_o}, {31'd0, e.ill});
        chk(e.req, "mtrap_we", {31'd0, mtrap_we_o}, {31'd0, e.mwe});
        if (e.mwe) begin
          chk(e.req, "mepc", mepc_o, e.mepc);
          chk(e.req, "mcause", mcause_o, e.mcause);
          chk(e.req, "mpp", {30'd0, mpp_o}, 32'd3);
        end
        chk(e.req, "rdata", csr_rdata_o, e.rdata);
      end
    end
  end

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    idle_rd("R1", 12'h350); idle_rd("R1", 12'h351); idle_rd("R1", 12'h352);
    idle_rd("R1", 12'h353); idle_rd("R1", 12'h300);
    // R4 register access and masking; R12 flag untouched by writes
    step("R4", 0, 0, 0, 0, 32'h100, 2'd3, 0, 1, 12'h350, 32'hA5A5_5A5A);
    idle_rd("R4", 12'h350);
    step("R4", 0, 0, 0, 0, 32'h100, 2'd3, 0, 1, 12'h351, 32'h0000_1235);
    idle_rd("R4", 12'h351);
    step("R4", 0, 0, 0, 0, 32'h100, 2'd3, 0, 1, 12'h352, 32'hDEAD_BEEF);
    idle_rd("R4", 12'h352);
    step("R12", 0, 0, 0, 0, 32'h100, 2'd3, 0, 1, 12'h353, 32'hFFFF_FFFF);
    idle_rd("R4", 12'h353);
    step("R12", 0, 0, 0, 0, 32'h100, 2'd3, 0, 1, 12'h353, 32'h0);
    // R10 exception while enabled
    step("R10", 0, 0, 1, 32'd13, 32'h400, 2'd0, 0, 0, 12'h351, 0);
    // R2 R3 entry from supervisor
    step("R2", 1, 4'd5, 0, 0, 32'h8000_0103, 2'd1, 0, 0, 12'h351, 0);
    idle_rd("R2", 12'h351);
    idle_rd("R3", 12'h352);
    idle_rd("R2", 12'h353);
    // R5 nested NMI held off
    step("R5", 1, 4'd9, 0, 0, 32'h1010, 2'd3, 0, 0, 12'h352, 0);
    idle_rd("R5", 12'h351);
    // R9 exception in handler
    step("R9", 0, 0, 1, 32'h0000_000D, 32'h1040, 2'd3, 0, 0, 12'h351, 0);
    idle_rd("R9", 12'h352);
    // R8 return from user while flag clear: routed like R9 with cause 2
    step("R8", 0, 0, 0, 0, 32'h1044, 2'd0, 1, 0, 12'h351, 0);
    // R7 legal return
    step("R7", 0, 0, 0, 0, 32'h1048, 2'd3, 1, 0, 12'h353, 0);
    idle_rd("R7", 12'h351);
    // R8 return from supervisor while enabled
    step("R8", 0, 0, 0, 0, 32'h500, 2'd1, 1, 0, 12'h351, 0);
    idle_rd("R8", 12'h353);
    // R6 NMI beats exception and return
    step("R6", 1, 4'd3, 1, 32'd7, 32'h2000, 2'd3, 1, 0, 12'h351, 0);
    idle_rd("R6", 12'h351);
    idle_rd("R6", 12'h353);
    step("R7", 0, 0, 0, 0, 32'h1050, 2'd3, 1, 0, 12'h351, 0);
    // R11 write collides with entry; R3 max code
    step("R11", 1, 4'hF, 0, 0, 32'h3000, 2'd0, 0, 1, 12'h351, 32'hFFFF_0000);
    idle_rd("R11", 12'h351);
    idle_rd("R3", 12'h352);
    step("R11", 0, 0, 0, 0, 32'h100, 2'd3, 0, 1, 12'h350, 32'h1234_5678);
    idle_rd("R12", 12'h350);
    step("R7", 0, 0, 0, 0, 32'h1060, 2'd3, 1, 0, 12'h353, 0);
    idle_rd("R7", 12'h300);
    @(negedge clk_i);
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule